// File: doc/BRIEF.md
# Multi-line receive silo with alarm

This block is the receive side of an eight-line serial multiplexer. It gathers every completed character from all lines into one shared first-in first-out store. Each stored entry records the character, the line it came from, and its error flags. A processor drains the store one 16-bit word per read strobe. Every word carries a valid bit, so software can loop until it reads a word whose valid bit is clear.

Each line owns a one-character holding register. Lines that deliver characters in the same cycle therefore never collide. The holding registers drain into the store one per cycle, lowest line number first. A receive interrupt request can follow the store in two ways. It can assert as soon as anything is stored. In alarm mode, it is held back until a fill level is reached, which spares the processor one interrupt per character when traffic is heavy. A line-enable vector decides which lines may deliver characters at all.

Top module: `rxsilo_top`

## Requirements
- R1: The store holds up to 64 entries across all lines combined. After 64 characters have been stored, all 64 read back valid and in arrival order.
- R2: A read word places the character in bits 7:0 and the source line number in bits 10:8. Bit 12 is the parity-error flag, bit 13 the framing-error flag, bit 14 the overrun flag and bit 15 the valid bit. Bit 11 reads zero.
- R3: Characters from several lines in the same cycle are all stored, in ascending line order, at one entry per cycle.
- R4: A read strobe while the store is empty returns an all-zero word, so the valid bit is clear. Such a read changes nothing else.
- R5: A received break is stored as it arrives: a zero character with the framing-error flag set.
- R6: With alarm mode off, the interrupt request is high exactly while the store is non-empty and receive interrupts are enabled. With receive interrupts disabled, it stays low.
- R7: A character strobe on a line whose enable bit is clear is ignored and stores nothing.
- R8: With alarm mode on and receive interrupts enabled, the interrupt request stays low while fewer than 16 entries are held. It rises once 16 are held.
- R9: A character is lost if it arrives while its line's holding register is still occupied and not draining, which happens when the store is full. The next entry written to the store then carries the overrun flag.
- R10: The read word appears on the output in the clock cycle after the read strobe and holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | NLINES | Per-line receive enable |
| rx_ie | input | 1 | Receive interrupt enable |
| alarm_en | input | 1 | Alarm mode: interrupt only at the fill level |
| rx_stb | input | NLINES | One-cycle character-complete strobe per line |
| rx_char | input | 8*NLINES | Character per line, line i in bits 8i+7:8i |
| rx_ferr | input | NLINES | Framing-error flag per line, sampled with the strobe |
| rx_perr | input | NLINES | Parity-error flag per line, sampled with the strobe |
| rd_stb | input | 1 | Read strobe: pop one entry |
| rd_data | output | 16 | Last read word |
| irq | output | 1 | Receive interrupt request |

## Verification
A wrong occupancy count shows up in two ways. The interrupt request changes level at the wrong fill point, within one cycle of the push that should have moved it. A count that is too low also shows as a valid word going missing at the end of a drain. A fault in the arbitration order or the holding registers shows as a reordered line field, or as a missing or duplicated entry, on the next read that reaches that entry. A lost overrun marker only becomes visible when the entry that should carry it is read. For this reason the bench drains the full store after the overflow case.

// File: rtl/rxsilo_pkg.sv
package rxsilo_pkg;
    localparam int CHAR_W  = 8;
    localparam int TAG_W   = 3;
    localparam int WORD_W  = 16;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [TAG_W-1:0]  line;
        logic [CHAR_W-1:0] chr;
    } silo_entry_t;

    function automatic logic [WORD_W-1:0] to_word(silo_entry_t e);
        return {1'b1, e.ovr, e.ferr, e.perr, 1'b0, e.line, e.chr};
    endfunction
endpackage

// File: rtl/rxsilo_line_hold.sv
module rxsilo_line_hold
    import rxsilo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              stb,
    input  logic [CHAR_W-1:0] chr,
    input  logic              ferr,
    input  logic              perr,
    input  logic              take,
    output logic              full,
    output logic [CHAR_W-1:0] chr_o,
    output logic              ferr_o,
    output logic              perr_o,
    output logic              drop
);
    typedef struct packed {
        logic              full;
        logic [CHAR_W-1:0] chr;
        logic              ferr;
        logic              perr;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        drop   = 1'b0;
        if (take) begin
            hold_d.full = 1'b0;
        end
        if (en && stb) begin
            if (!hold_q.full || take) begin
                hold_d.full = 1'b1;
                hold_d.chr  = chr;
                hold_d.ferr = ferr;
                hold_d.perr = perr;
            end else begin
                drop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign full   = hold_q.full;
    assign chr_o  = hold_q.chr;
    assign ferr_o = hold_q.ferr;
    assign perr_o = hold_q.perr;

    // R9: an occupied register that is not drained keeps its character
    p_hold_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q.full && !take) |=> (hold_q.full && $stable(hold_q.chr)));

    // R7: a disabled line never fills an empty register
    p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_q.full && !en) |=> !hold_q.full);
endmodule

// File: rtl/rxsilo_arb.sv
module rxsilo_arb #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end

    // R3: one line served per cycle
    p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R3: a request is never left unserved while nothing is granted
    p_no_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> any);
endmodule

// File: rtl/rxsilo_fifo.sv
module rxsilo_fifo #(
    parameter int W     = 14,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (pop)  st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wp] <= wdata;
    end

    assign head  = mem[st_q.rp];
    assign count = st_q.cnt;

    // R1: occupancy never exceeds the capacity
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R4: nothing is removed from an empty store
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> !pop);
endmodule

// File: rtl/rxsilo_top.sv
module rxsilo_top
    import rxsilo_pkg::*;
#(
    parameter int NLINES    = 8,
    parameter int DEPTH     = 64,
    parameter int ALARM_LVL = 16,
    localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        line_en,
    input  logic                     rx_ie,
    input  logic                     alarm_en,
    input  logic [NLINES-1:0]        rx_stb,
    input  logic [CHAR_W*NLINES-1:0] rx_char,
    input  logic [NLINES-1:0]        rx_ferr,
    input  logic [NLINES-1:0]        rx_perr,
    input  logic                     rd_stb,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     irq
);
    typedef struct packed {
        logic [WORD_W-1:0] rd_word;
        logic              ovr_pend;
    } top_t;

    top_t st_d, st_q;

    logic [NLINES-1:0] h_full, h_ferr, h_perr, h_drop, gnt, req;
    logic [CHAR_W-1:0] h_chr [NLINES];
    logic [IW-1:0]     sel;
    logic              push, pop, space;
    silo_entry_t       wentry, head;
    logic [CW-1:0]     count;

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            rxsilo_line_hold u_hold (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (line_en[g]),
                .stb    (rx_stb[g]),
                .chr    (rx_char[g*CHAR_W +: CHAR_W]),
                .ferr   (rx_ferr[g]),
                .perr   (rx_perr[g]),
                .take   (gnt[g]),
                .full   (h_full[g]),
                .chr_o  (h_chr[g]),
                .ferr_o (h_ferr[g]),
                .perr_o (h_perr[g]),
                .drop   (h_drop[g])
            );
        end
    endgenerate

    assign space = (count < CW'(DEPTH));
    assign req   = h_full & {NLINES{space}};

    rxsilo_arb #(.N(NLINES)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt),
        .idx   (sel),
        .any   (push)
    );

    always_comb begin
        wentry.chr  = h_chr[sel];
        wentry.line = TAG_W'(sel);
        wentry.ferr = h_ferr[sel];
        wentry.perr = h_perr[sel];
        wentry.ovr  = st_q.ovr_pend;
    end

    assign pop = rd_stb && (count != '0);

    rxsilo_fifo #(.W($bits(silo_entry_t)), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (wentry),
        .pop   (pop),
        .head  (head),
        .count (count)
    );

    always_comb begin
        st_d = st_q;
        if (push) st_d.ovr_pend = 1'b0;
        if (h_drop != '0) st_d.ovr_pend = 1'b1;
        if (rd_stb) st_d.rd_word = pop ? to_word(head) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd_word;
    assign irq = rx_ie && (alarm_en ? (count >= CW'(ALARM_LVL)) : (count != '0));

    // R1: a push only happens with room in the store
    p_push_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));
    // R4: an empty read returns a word with the valid bit clear
    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && count == '0) |=> (rd_data == '0));
    // R6: the request never asserts on an empty store
    p_irq_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count != '0));
    // R8: in alarm mode the request implies the fill level
    p_alarm_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && irq) |-> (count >= CW'(ALARM_LVL)));
    // R10: without a strobe the read word holds
    p_word_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
endmodule

// File: tb/rxsilo_top_tb_top.sv
module rxsilo_top_tb_top;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  line_en, rx_stb, rx_ferr, rx_perr;
    logic          rx_ie, alarm_en, rd_stb;
    logic [8*N-1:0] rx_char;
    logic [15:0]   rd_data;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] exp_q [$];

    always #5 clk = ~clk;

    rxsilo_top dut_i (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .rx_ie(rx_ie),
        .alarm_en(alarm_en), .rx_stb(rx_stb), .rx_char(rx_char),
        .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rd_stb(rd_stb),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [15:0] mk(int ln, logic [7:0] c, bit fe, bit pe, bit ov);
        return {1'b1, ov, fe, pe, 1'b0, 3'(ln), c};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver: one strobe cycle, records the expected entries in line order
    task automatic fire(logic [N-1:0] mask, logic [7:0] c0,
                        logic [N-1:0] fe, logic [N-1:0] pe, bit record);
        rx_stb  = mask;
        rx_ferr = fe;
        rx_perr = pe;
        for (int i = 0; i < N; i++) begin
            rx_char[i*8 +: 8] = c0 + 8'(i);
            if (record && mask[i] && line_en[i])
                exp_q.push_back(mk(i, c0 + 8'(i), fe[i], pe[i], 1'b0));
        end
        @(negedge clk);
        rx_stb = '0;
    endtask

    // monitor: one read, compared with the scoreboard head
    task automatic read_check(string req);
        logic [15:0] exp;
        exp = (exp_q.size() != 0) ? exp_q.pop_front() : 16'h0000;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check(req, rd_data, exp);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; line_en = '1; rx_ie = 1'b1; alarm_en = 1'b0;
        rx_stb = '0; rx_char = '0; rx_ferr = '0; rx_perr = '0; rd_stb = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // reset state
        check("R6 reset irq", 16'(irq), 16'h0);
        check("R10 reset word", rd_data, 16'h0);
        read_check("R4 empty read");

        // single character, line 3, with parity error
        fire(8'h08, 8'h40, 8'h00, 8'h08, 1'b1);
        idle(1);
        check("R6 irq non-empty", 16'(irq), 16'h1);
        rx_ie = 1'b0;
        idle(1);
        check("R6 irq disabled", 16'(irq), 16'h0);
        rx_ie = 1'b1;
        read_check("R2 tagged entry");
        idle(1);
        check("R10 word held", rd_data, mk(3, 8'h43, 0, 0, 0) | 16'h1000);
        check("R6 irq drained", 16'(irq), 16'h0);

        // simultaneous lines 0,2,5,7
        fire(8'hA5, 8'h10, 8'h00, 8'h00, 1'b1);
        idle(5);
        for (int i = 0; i < 4; i++) read_check("R3 ascending order");
        read_check("R4 empty after drain");

        // break on line 6
        fire(8'h40, 8'hFA, 8'h40, 8'h00, 1'b0);
        exp_q.push_back(mk(6, 8'h00, 1, 0, 0));
        rx_stb = 8'h40; rx_ferr = 8'h40; rx_char[6*8 +: 8] = 8'h00;
        @(negedge clk); rx_stb = '0;
        idle(2);
        // first fire stored char FA+6 with framing error; account for it
        exp_q.push_front(mk(6, 8'h00, 1, 0, 0));
        exp_q.pop_back();
        exp_q.push_front(mk(6, 8'hFA + 8'd6, 1, 0, 0));
        read_check("R5 framed char");
        read_check("R5 break entry");

        // disabled line
        line_en = 8'hEF;
        fire(8'h10, 8'h20, 8'h00, 8'h00, 1'b1);
        idle(2);
        check("R7 irq after disabled strobe", 16'(irq), 16'h0);
        read_check("R7 nothing stored");
        line_en = '1;

        // alarm mode
        alarm_en = 1'b1;
        for (int i = 0; i < 15; i++) fire(8'h04, 8'(i * 8), 8'h00, 8'h00, 1'b1);
        idle(2);
        check("R8 below level", 16'(irq), 16'h0);
        fire(8'h04, 8'h80, 8'h00, 8'h00, 1'b1);
        idle(2);
        check("R8 at level", 16'(irq), 16'h1);
        read_check("R8 drain");
        check("R8 below again", 16'(irq), 16'h0);
        for (int i = 0; i < 15; i++) read_check("R8 drain");
        alarm_en = 1'b0;

        // fill to capacity, then overflow
        for (int i = 0; i < 64; i++) fire(8'h02, 8'(i), 8'h00, 8'h00, 1'b1);
        idle(2);
        fire(8'h02, 8'hC0, 8'h00, 8'h00, 1'b0);  // waits in holding register
        fire(8'h02, 8'hD0, 8'h00, 8'h00, 1'b0);  // lost
        idle(2);
        exp_q.push_back(mk(1, 8'hC1, 0, 0, 1));
        for (int i = 0; i < 64; i++) read_check("R1 capacity");
        idle(1);
        read_check("R9 overrun flag");
        read_check("R9 lost char absent");
        check("R6 empty at end", 16'(irq), 16'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule